// File: doc/BRIEF.md
# Write-Behind Store Queue with Load Forwarding

This block sits between a processor core's memory port and its first-level data cache. A store from the core is taken into a small circular queue in the same cycle it is presented, so the core never waits on the cache for a write. In the background the queue writes its oldest entry to the cache whenever the cache write port signals ready. Entries leave strictly in the order the core issued them.

A load is always accepted. If its address matches any queued store, the youngest such store supplies the data. Otherwise the load is sent to the cache read port in the same cycle. In both cases the response comes one cycle later. Queued stores stay invisible to the cache, and so to every other agent, until they drain.

A fence is held off until the queue is empty. This gives software a full ordering point. Without a fence, the only reordering the block can introduce is a later load passing an earlier store to a different address.

Top module: `store_drain_buffer`

## Requirements
- R1: A store (core_kind 2'b01) is accepted in the cycle it is presented, with core_ready high, whenever fewer than DEPTH entries are held.
- R2: A store presented while DEPTH entries are held sees core_ready low and stays pending. It is accepted in the first cycle after a slot has been freed by a drain.
- R3: cache_wr_valid is high exactly when the queue holds an entry, and it presents the oldest entry. That entry leaves only on a cycle where cache_wr_ready is high, and at most one entry leaves per cycle. While the cache is not ready, the address and data hold steady.
- R4: Entries are written to the cache in exactly the order the stores were accepted, including repeated stores to the same address.
- R5: A queued store causes no cache write until it drains. While cache_wr_ready stays low, cache contents are unchanged.
- R6: A load (core_kind 2'b00) is accepted in the cycle it is presented. rsp_valid is high for exactly the following cycle.
- R7: A load whose address matches one or more queued stores returns the data of the most recently accepted matching store.
- R8: A load with no matching queued store raises cache_rd_en with cache_rd_addr equal to the load address in its acceptance cycle. It returns the word the cache supplies on cache_rd_data in the next cycle.
- R9: A fence (core_kind 2'b10 or 2'b11) sees core_ready low while any entry is held. It is accepted only once the queue is empty.
- R10: After reset the queue is empty: cache_wr_valid and rsp_valid are low and a fence is ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| core_valid | input | 1 | Core presents an operation |
| core_kind | input | 2 | 00 load, 01 store, 1x fence |
| core_addr | input | AW | Word address of a load or store |
| core_wdata | input | DW | Store data |
| core_ready | output | 1 | Operation is accepted this cycle when core_valid is high |
| rsp_valid | output | 1 | Load data valid |
| rsp_data | output | DW | Load data |
| cache_wr_valid | output | 1 | Oldest queued store offered to the cache |
| cache_wr_ready | input | 1 | Cache takes the offered store this cycle |
| cache_wr_addr | output | AW | Address of offered store |
| cache_wr_data | output | DW | Data of offered store |
| cache_rd_en | output | 1 | Read request to the cache |
| cache_rd_addr | output | AW | Read address |
| cache_rd_data | input | DW | Cache read data, one cycle after cache_rd_en |

## Verification
The address space is kept to sixteen words so that loads sweep every address. Some sweeps run against a full queue that holds repeated stores to four addresses; these separate youngest-match forwarding from oldest-match and from cache reads. The same sweep after a complete drain confirms that the unmatched path returns cache contents. A held store against a full queue, with the cache write port closed and then opened, distinguishes correct stall and release timing from an early or duplicated accept. A final mixed sequence of loads, stores and fences under a toggling cache ready compares the cache's write log against the acceptance order and every load against an arithmetic model of memory.

// File: rtl/sdb_pkg.sv
package sdb_pkg;
  // Operation codes on core_kind; bit 1 set means fence.
  typedef enum logic [1:0] {
    OP_LOAD   = 2'b00,
    OP_STORE  = 2'b01,
    OP_FENCE  = 2'b10,
    OP_FENCE2 = 2'b11
  } sdb_op_e;
endpackage

// File: rtl/sdb_ring.sv
// Circular entry storage with head/tail pointers. DEPTH must be a power of two.
module sdb_ring #(
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int DEPTH = 8
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       push,
  input  logic [AW-1:0]              push_addr,
  input  logic [DW-1:0]              push_data,
  input  logic                       pop,
  output logic [AW-1:0]              head_addr,
  output logic [DW-1:0]              head_data,
  output logic [$clog2(DEPTH)-1:0]   head_ptr,
  output logic [$clog2(DEPTH+1)-1:0] count,
  output logic                       empty,
  output logic                       full,
  output logic [DEPTH*AW-1:0]        tag_flat,
  output logic [DEPTH*DW-1:0]        data_flat
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH+1);

  logic [AW-1:0]    tag_q [DEPTH];
  logic [DW-1:0]    dat_q [DEPTH];
  logic [PTR_W-1:0] head_q, tail_q;
  logic [CNT_W-1:0] cnt_q;

  // Entry payload: written without reset, single write port.
  always_ff @(posedge clk) begin
    if (push) begin
      tag_q[tail_q] <= push_addr;
      dat_q[tail_q] <= push_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      head_q <= '0;
      tail_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (push) tail_q <= tail_q + 1'b1;
      if (pop)  head_q <= head_q + 1'b1;
      cnt_q <= cnt_q + CNT_W'(push) - CNT_W'(pop);
    end
  end

  genvar g;
  generate
    for (g = 0; g < DEPTH; g++) begin : g_flat
      assign tag_flat[g*AW +: AW]  = tag_q[g];
      assign data_flat[g*DW +: DW] = dat_q[g];
    end
  endgenerate

  assign head_addr = tag_q[head_q];
  assign head_data = dat_q[head_q];
  assign head_ptr  = head_q;
  assign count     = cnt_q;
  assign empty     = (cnt_q == '0);
  assign full      = (cnt_q == CNT_W'(DEPTH));
endmodule

// File: rtl/sdb_match.sv
// Address search over live entries; the youngest match wins.
module sdb_match #(
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int DEPTH = 8
) (
  input  logic [DEPTH*AW-1:0]        tag_flat,
  input  logic [DEPTH*DW-1:0]        data_flat,
  input  logic [$clog2(DEPTH)-1:0]   head_ptr,
  input  logic [$clog2(DEPTH+1)-1:0] count,
  input  logic [AW-1:0]              look_addr,
  output logic                       hit,
  output logic [DW-1:0]              hit_data
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH+1);

  logic [PTR_W-1:0] slot;

  // Walk from oldest to youngest; a later match overrides an earlier one.
  always_comb begin
    hit      = 1'b0;
    hit_data = '0;
    slot     = head_ptr;
    for (int k = 0; k < DEPTH; k++) begin
      slot = head_ptr + PTR_W'(k);
      if ((CNT_W'(k) < count) && (tag_flat[slot*AW +: AW] == look_addr)) begin
        hit      = 1'b1;
        hit_data = data_flat[slot*DW +: DW];
      end
    end
  end
endmodule

// File: rtl/store_drain_buffer.sv
module store_drain_buffer #(
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int DEPTH = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          core_valid,
  input  logic [1:0]    core_kind,
  input  logic [AW-1:0] core_addr,
  input  logic [DW-1:0] core_wdata,
  output logic          core_ready,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_data,
  output logic          cache_wr_valid,
  input  logic          cache_wr_ready,
  output logic [AW-1:0] cache_wr_addr,
  output logic [DW-1:0] cache_wr_data,
  output logic          cache_rd_en,
  output logic [AW-1:0] cache_rd_addr,
  input  logic [DW-1:0] cache_rd_data
);
  import sdb_pkg::*;

  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH+1);

  logic                is_load, is_store, is_fence, accept;
  logic                push, pop, empty, full;
  logic [PTR_W-1:0]    head_ptr;
  logic [CNT_W-1:0]    count;
  logic [DEPTH*AW-1:0] tag_flat;
  logic [DEPTH*DW-1:0] data_flat;
  logic                hit;
  logic [DW-1:0]       hit_data;
  logic                rsp_q, fwd_q;
  logic [DW-1:0]       fwd_data_q;

  assign is_load  = (core_kind == OP_LOAD);
  assign is_store = (core_kind == OP_STORE);
  assign is_fence = core_kind[1];

  // Store waits for a free slot; fence waits for an empty queue.
  always_comb begin
    if (is_store)      core_ready = !full;
    else if (is_fence) core_ready = empty;
    else               core_ready = 1'b1;
  end

  assign accept = core_valid && core_ready;
  assign push   = accept && is_store;
  assign pop    = !empty && cache_wr_ready;

  sdb_ring #(.AW(AW), .DW(DW), .DEPTH(DEPTH)) u_ring (
    .clk       (clk),
    .rst       (rst),
    .push      (push),
    .push_addr (core_addr),
    .push_data (core_wdata),
    .pop       (pop),
    .head_addr (cache_wr_addr),
    .head_data (cache_wr_data),
    .head_ptr  (head_ptr),
    .count     (count),
    .empty     (empty),
    .full      (full),
    .tag_flat  (tag_flat),
    .data_flat (data_flat)
  );

  sdb_match #(.AW(AW), .DW(DW), .DEPTH(DEPTH)) u_match (
    .tag_flat  (tag_flat),
    .data_flat (data_flat),
    .head_ptr  (head_ptr),
    .count     (count),
    .look_addr (core_addr),
    .hit       (hit),
    .hit_data  (hit_data)
  );

  assign cache_wr_valid = !empty;
  assign cache_rd_en    = accept && is_load && !hit;
  assign cache_rd_addr  = core_addr;

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_q      <= 1'b0;
      fwd_q      <= 1'b0;
      fwd_data_q <= '0;
    end else begin
      rsp_q      <= accept && is_load;
      fwd_q      <= hit;
      fwd_data_q <= hit_data;
    end
  end

  assign rsp_valid = rsp_q;
  assign rsp_data  = fwd_q ? fwd_data_q : cache_rd_data;
endmodule

// File: rtl/sdb_checker.sv
module sdb_checker #(
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int DEPTH = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          core_valid,
  input logic [1:0]    core_kind,
  input logic          core_ready,
  input logic          rsp_valid,
  input logic          cache_wr_valid,
  input logic          cache_wr_ready,
  input logic [AW-1:0] cache_wr_addr,
  input logic [DW-1:0] cache_wr_data
);
  localparam int CNT_W = $clog2(DEPTH+1);

  logic [CNT_W-1:0] occ;
  logic st_acc, ld_acc, drained;

  assign st_acc  = core_valid && core_ready && (core_kind == 2'b01);
  assign ld_acc  = core_valid && core_ready && (core_kind == 2'b00);
  assign drained = cache_wr_valid && cache_wr_ready;

  always_ff @(posedge clk) begin
    if (rst) occ <= '0;
    else     occ <= occ + CNT_W'(st_acc) - CNT_W'(drained);
  end

  assert_no_overflow_R2: assert property (@(posedge clk) disable iff (rst)
    occ <= CNT_W'(DEPTH));

  assert_full_stall_R2: assert property (@(posedge clk) disable iff (rst)
    (core_kind == 2'b01 && occ == CNT_W'(DEPTH)) |-> !core_ready);

  assert_wr_valid_R3: assert property (@(posedge clk) disable iff (rst)
    cache_wr_valid == (occ != '0));

  assert_wr_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (cache_wr_valid && !cache_wr_ready) |=>
      (cache_wr_valid && $stable(cache_wr_addr) && $stable(cache_wr_data)));

  assert_rsp_next_R6: assert property (@(posedge clk) disable iff (rst)
    ld_acc |=> rsp_valid);

  assert_rsp_only_R6: assert property (@(posedge clk) disable iff (rst)
    !ld_acc |=> !rsp_valid);

  assert_fence_empty_R9: assert property (@(posedge clk) disable iff (rst)
    (core_valid && core_ready && core_kind[1]) |-> (occ == '0));

  assert_reset_R10: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!rsp_valid && !cache_wr_valid));
endmodule

bind store_drain_buffer sdb_checker #(.AW(AW), .DW(DW), .DEPTH(DEPTH)) u_chk (
  .clk            (clk),
  .rst            (rst),
  .core_valid     (core_valid),
  .core_kind      (core_kind),
  .core_ready     (core_ready),
  .rsp_valid      (rsp_valid),
  .cache_wr_valid (cache_wr_valid),
  .cache_wr_ready (cache_wr_ready),
  .cache_wr_addr  (cache_wr_addr),
  .cache_wr_data  (cache_wr_data)
);

// File: tb/store_drain_buffer_tb.sv
`timescale 1ns/1ps
module store_drain_buffer_tb;
  localparam int AW = 4;
  localparam int DW = 16;
  localparam int DEPTH = 8;
  localparam int NW = 1 << AW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic core_valid = 1'b0;
  logic [1:0] core_kind = 2'b00;
  logic [AW-1:0] core_addr = '0;
  logic [DW-1:0] core_wdata = '0;
  logic core_ready, rsp_valid, cache_wr_valid, cache_rd_en;
  logic [DW-1:0] rsp_data, cache_wr_data;
  logic [AW-1:0] cache_wr_addr, cache_rd_addr;
  logic cache_wr_ready = 1'b0;
  logic [DW-1:0] cache_rd_data;

  always #5 clk = ~clk;

  store_drain_buffer #(.AW(AW), .DW(DW), .DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst(rst), .core_valid(core_valid), .core_kind(core_kind),
    .core_addr(core_addr), .core_wdata(core_wdata), .core_ready(core_ready),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .cache_wr_valid(cache_wr_valid), .cache_wr_ready(cache_wr_ready),
    .cache_wr_addr(cache_wr_addr), .cache_wr_data(cache_wr_data),
    .cache_rd_en(cache_rd_en), .cache_rd_addr(cache_rd_addr),
    .cache_rd_data(cache_rd_data)
  );

  // Cache model with a write log.
  logic [DW-1:0] cmem [NW];
  logic [AW-1:0] wlog_a [256];
  logic [DW-1:0] wlog_d [256];
  int wcnt = 0;
  always @(posedge clk) begin
    if (!rst && cache_wr_valid && cache_wr_ready) begin
      cmem[cache_wr_addr] <= cache_wr_data;
      wlog_a[wcnt] <= cache_wr_addr;
      wlog_d[wcnt] <= cache_wr_data;
      wcnt <= wcnt + 1;
    end
    if (cache_rd_en) cache_rd_data <= cmem[cache_rd_addr];
  end

  // Architectural model.
  logic [DW-1:0] arch [NW];
  logic [AW-1:0] eq_a [256];
  logic [DW-1:0] eq_d [256];
  int eq_n = 0;
  int n_chk = 0;
  int n_fail = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Issue one operation; returns the number of stalled cycles.
  task automatic do_op(input logic [1:0] kind, input logic [AW-1:0] a,
                       input logic [DW-1:0] d, output int waits);
    @(negedge clk);
    core_valid = 1'b1; core_kind = kind; core_addr = a; core_wdata = d;
    #1;
    waits = 0;
    while (!core_ready && waits < 1000) begin
      @(negedge clk); #1;
      waits++;
      if (waits > 2) cache_wr_ready = 1'b1;
    end
    @(posedge clk); #1;
    core_valid = 1'b0;
    if (kind == 2'b01) begin
      arch[a] = d; eq_a[eq_n] = a; eq_d[eq_n] = d; eq_n++;
    end
    if (kind == 2'b00) begin
      @(negedge clk); #1;
      chk(rsp_valid === 1'b1, "R6 rsp_valid", {31'b0, rsp_valid}, 1);
      chk(rsp_data === arch[a], (a < 4 && eq_n > wcnt) ? "R7 forward" : "R8 cache read",
          {16'b0, rsp_data}, {16'b0, arch[a]});
    end
  endtask

  task automatic check_log(input string tag);
    chk(wcnt == eq_n, "R4 drain count", wcnt, eq_n);
    for (int i = 0; i < eq_n && i < wcnt; i++)
      chk(wlog_a[i] == eq_a[i] && wlog_d[i] == eq_d[i], tag,
          {12'b0, wlog_a[i], wlog_d[i]}, {12'b0, eq_a[i], eq_d[i]});
  endtask

  initial begin
    #2_000_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int w;
    for (int i = 0; i < NW; i++) begin
      cmem[i] = 16'h1000 + 16'(i);
      arch[i] = 16'h1000 + 16'(i);
    end
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    core_kind = 2'b10; #1;
    chk(core_ready === 1'b1, "R10 fence ready after reset", {31'b0, core_ready}, 1);
    chk(cache_wr_valid === 1'b0, "R10 wr_valid low", {31'b0, cache_wr_valid}, 0);
    chk(rsp_valid === 1'b0, "R10 rsp_valid low", {31'b0, rsp_valid}, 0);

    // Fill the queue with repeated addresses; cache closed.
    for (int i = 0; i < DEPTH; i++) begin
      do_op(2'b01, AW'(i % 4), 16'hA000 + 16'(i), w);
      chk(w == 0, "R1 single-cycle store", w, 0);
    end
    chk(cmem[0] == 16'h1000 && wcnt == 0, "R5 no cache write", {16'b0, cmem[0]}, 32'h1000);

    // Fence blocked while entries remain.
    @(negedge clk); core_kind = 2'b11; #1;
    chk(core_ready === 1'b0, "R9 fence stalls", {31'b0, core_ready}, 0);
    core_kind = 2'b10; #1;
    chk(core_ready === 1'b0, "R9 fence stalls", {31'b0, core_ready}, 0);

    // Sweep every address against the full queue.
    for (int a = 0; a < NW; a++) do_op(2'b00, AW'(a), '0, w);

    // Store against a full queue.
    @(negedge clk);
    core_valid = 1'b1; core_kind = 2'b01; core_addr = 4'd5; core_wdata = 16'hB000;
    for (int k = 0; k < 3; k++) begin
      #1;
      chk(core_ready === 1'b0, "R2 full stall", {31'b0, core_ready}, 0);
      chk(cmem[1] == 16'h1001 && wcnt == 0, "R5 cache untouched", {16'b0, cmem[1]}, 32'h1001);
      @(negedge clk);
    end
    cache_wr_ready = 1'b1; #1;
    chk(core_ready === 1'b0, "R2 still full at release", {31'b0, core_ready}, 0);
    for (int k = 1; k <= 10; k++) begin
      @(negedge clk); #1;
      if (k == 1) chk(core_ready === 1'b1, "R2 slot freed", {31'b0, core_ready}, 1);
      if (k == 2) begin
        core_valid = 1'b0;
        arch[5] = 16'hB000; eq_a[eq_n] = 4'd5; eq_d[eq_n] = 16'hB000; eq_n++;
      end
      if (k <= 9) chk(wcnt == k, "R3 one drain per cycle", wcnt, k);
      else chk(wcnt == 9 && cache_wr_valid === 1'b0, "R3 empty after drain", wcnt, 9);
    end
    check_log("R4 program order");

    @(negedge clk); core_kind = 2'b10; #1;
    chk(core_ready === 1'b1, "R9 fence ready when empty", {31'b0, core_ready}, 1);
    for (int a = 0; a < NW; a++) do_op(2'b00, AW'(a), '0, w);
    for (int a = 0; a < NW; a++)
      chk(cmem[a] == arch[a], "R4 final cache image", {16'b0, cmem[a]}, {16'b0, arch[a]});

    // Mixed sequence under a toggling cache ready.
    for (int n = 0; n < 96; n++) begin
      logic [1:0] kind;
      kind = (n % 5 == 4) ? 2'b10 : ((n % 2 == 0) ? 2'b01 : 2'b00);
      cache_wr_ready = (kind == 2'b10) ? 1'b1 : (n % 4 != 1);
      do_op(kind, AW'((n * 7) % NW), 16'hC000 + 16'(n * 3), w);
      if (kind == 2'b10) chk(wcnt == eq_n, "R9 fence after full drain", wcnt, eq_n);
    end
    cache_wr_ready = 1'b1;
    repeat (DEPTH + 2) @(negedge clk);
    check_log("R4 mixed order");

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule